// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a clocked static memory whose bus never needs an idle cycle when it turns from reading to writing or back. On a rising clock edge it samples a new address and the command pins. When `load_n` is high it samples an address only, and keeps the operation type of the previous cycle, so an outside burst address generator can feed it one address per cycle. A read puts the selected word on `rdata` in the cycle that follows the edge that took the command (flow-through). For a write, the address and byte mask are taken on one edge and the data one edge later.

Written words wait in a one-entry late-write buffer. The buffer is copied into the array when the next write replaces it. Reads merge the buffered lanes over the array word, so a read always returns the newest data. A `suspend` input freezes every register. Three select inputs of mixed polarity gate selection, for depth expansion. Each word is split into 9-bit byte lanes, and a lane is written only when its write-enable bit is low.

Top module: `nws_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no command taken, `rvalid` is 0 and `rdata` is all zero.
- R2: An edge with `load_n`=0 and `suspend`=0 starts a new cycle. It is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. When selected, `wr_n`=0 gives a write and `wr_n`=1 gives a read. Any other select combination gives a deselect cycle, which writes nothing and shows `rvalid`=0 and `rdata`=0 in the next cycle.
- R3: After the edge that takes a read, `rdata` holds the word at that address during the next clock cycle, with `rvalid`=1, provided `oe_n` was 0 at that edge. If `oe_n` was 1, `rvalid` is 0 and `rdata` is all zero.
- R4: Write data is driven in the cycle after the write command and is taken on the next edge that is not suspended. Lane i is bits [9i+8:9i]. Only lanes whose `byte_wr_n[i]` was 0 at the command edge change.
- R5: A read of an address that was written one or more cycles earlier returns the new lanes merged over the old ones. This includes a read taken on the same edge as that write's data.
- R6: Reads and writes can alternate on every cycle with no idle cycle between them. No cycle that is not a read shows `rvalid`=1.
- R7: An edge with `suspend`=1 is ignored. The outputs hold, write data on `wdata` is not taken, and the address and command inputs have no effect.
- R8: An edge with `load_n`=1 repeats the previous operation type (read, write or deselect) at the newly sampled address and byte mask. `wr_n` and the three select inputs are ignored.
- R9: A write with every `byte_wr_n` bit at 1 leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend | input | 1 | 1 = ignore this clock edge |
| load_n | input | 1 | 0 = start a new cycle, 1 = continue the current operation |
| sel_a_n | input | 1 | Select input, active low |
| sel_b | input | 1 | Select input, active high |
| sel_c_n | input | 1 | Select input, active low |
| wr_n | input | 1 | 0 = write, 1 = read (new cycles only) |
| byte_wr_n | input | LANES | Per-lane write enable, active low |
| oe_n | input | 1 | Output enable, active low, registered |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, one cycle after the command |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
A corrupted late-write buffer shows nothing until the next read of the buffered address. The read taken on the same edge as the data capture is the earliest point, so the bench follows each write with an immediate read. A bad op register shows within one cycle as `rvalid` in the wrong slot, or as a write landing after a deselect. A write that leaks through a suspended edge shows only when the address it touched is read later. For that reason the suspend tests read back the addresses the ignored commands carried.

// File: rtl/nws_sram_pkg.sv
package nws_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // device selected only for the one polarity pattern of the three enables
  function automatic logic chip_selected(input logic en_a_n, input logic en_b,
                                         input logic en_c_n);
    return (!en_a_n) && en_b && (!en_c_n);
  endfunction

  function automatic op_e decode_start(input logic selected, input logic wr_n);
    if (!selected) return OP_IDLE;
    return wr_n ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/nws_cmd_reg.sv
module nws_cmd_reg
  import nws_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic              load_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  wmask_q,
  output logic              oe_q
);

  logic sel_now;
  logic start_cycle;
  op_e  start_op;
  op_e  next_op;

  assign sel_now     = chip_selected(sel_a_n, sel_b, sel_c_n);
  assign start_op    = decode_start(sel_now, wr_n);
  assign start_cycle = !suspend && !load_n;

  always_comb begin
    next_op = load_n ? op_q : start_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wmask_q <= '0;
      oe_q    <= 1'b0;
    end else if (!suspend) begin
      op_q    <= next_op;
      addr_q  <= addr;
      wmask_q <= ~byte_wr_n;
      oe_q    <= !oe_n;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (op_q == OP_IDLE)); // R1

  AST_START_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cycle && !sel_now) |=> (op_q == OP_IDLE)); // R2

  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cycle && sel_now && !wr_n) |=> (op_q == OP_WRITE)); // R2

  AST_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cycle && sel_now && wr_n) |=> (op_q == OP_READ)); // R2

  AST_CONTINUE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && load_n) |=> $stable(op_q)); // R8

  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> ($stable(op_q) && $stable(addr_q) && $stable(wmask_q) && $stable(oe_q))); // R7

endmodule

// File: rtl/nws_late_write.sv
module nws_late_write
  import nws_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]  wmask_q,
  input  logic [DATA_W-1:0] wdata,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_mask,
  output logic [DATA_W-1:0] pend_data,
  output logic              commit_en
);

  logic capture_en;

  // data for the registered write command arrives now; older entry retires
  assign capture_en = !suspend && (op_q == OP_WRITE);
  assign commit_en  = capture_en && pend_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_mask  <= '0;
      pend_data  <= '0;
    end else if (capture_en) begin
      pend_valid <= 1'b1;
      pend_addr  <= addr_q;
      pend_mask  <= wmask_q;
      pend_data  <= wdata;
    end
  end

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (pend_valid && pend_addr == $past(addr_q) && pend_mask == $past(wmask_q))); // R4

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> ($stable(pend_data) && $stable(pend_addr) && $stable(pend_valid))); // R7

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |=> pend_valid); // R5

endmodule

// File: rtl/nws_array.sv
module nws_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) cells[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/nws_read_path.sv
module nws_read_path
  import nws_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  op_e               op_q,
  input  logic              oe_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] array_word,
  input  logic              pend_valid,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [LANES-1:0]  pend_mask,
  input  logic [DATA_W-1:0] pend_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  function automatic logic [DATA_W-1:0] merge_lanes(input logic [LANES-1:0] mask,
                                                    input logic [DATA_W-1:0] newer,
                                                    input logic [DATA_W-1:0] older);
    logic [DATA_W-1:0] res;
    res = older;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) res[i*LANE_W +: LANE_W] = newer[i*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  logic              bypass_hit;
  logic              drive_now;
  logic [DATA_W-1:0] fresh_word;

  assign bypass_hit = pend_valid && (pend_addr == addr_q);
  assign fresh_word = bypass_hit ? merge_lanes(pend_mask, pend_data, array_word) : array_word;
  assign drive_now  = (op_q == OP_READ) && oe_q;
  assign rvalid     = drive_now;
  assign rdata      = drive_now ? fresh_word : '0;

endmodule

// File: rtl/nws_sram.sv
module nws_sram
  import nws_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic              load_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  wmask_q;
  logic              oe_q;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_mask;
  logic [DATA_W-1:0] pend_data;
  logic              commit_en;
  logic [DATA_W-1:0] array_word;

  nws_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .load_n(load_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
    .byte_wr_n(byte_wr_n), .oe_n(oe_n), .addr(addr),
    .op_q(op_q), .addr_q(addr_q), .wmask_q(wmask_q), .oe_q(oe_q)
  );

  nws_late_write #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lw (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .op_q(op_q),
    .addr_q(addr_q), .wmask_q(wmask_q), .wdata(wdata),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_mask(pend_mask),
    .pend_data(pend_data), .commit_en(commit_en)
  );

  nws_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .wr_en(commit_en), .wr_addr(pend_addr), .wr_mask(pend_mask),
    .wr_word(pend_data), .rd_addr(addr_q), .rd_word(array_word)
  );

  nws_read_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .op_q(op_q), .oe_q(oe_q), .addr_q(addr_q), .array_word(array_word),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_mask(pend_mask),
    .pend_data(pend_data), .rdata(rdata), .rvalid(rvalid)
  );

  AST_NONREAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_READ) |-> (!rvalid && rdata == '0)); // R6

  AST_READ_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_READ && oe_q) |-> rvalid); // R3

  AST_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (op_q == OP_WRITE && !suspend)); // R4

endmodule

// File: tb/nws_sram_test.sv
`timescale 1ns/1ps
module nws_sram_test;

  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int NW = 1 << AW;
  localparam int K_IDLE = 0;
  localparam int K_RD   = 1;
  localparam int K_WR   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          suspend = 1'b0;
  logic          load_n = 1'b1;
  logic          sel_a_n = 1'b1;
  logic          sel_b = 1'b0;
  logic          sel_c_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [NL-1:0] byte_wr_n = '1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #4 clk = ~clk;

  nws_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .load_n(load_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
    .byte_wr_n(byte_wr_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [NW];
  int            last_op = K_IDLE;
  int            prev_kind = K_IDLE;
  int            prev_addr = 0;
  logic [NL-1:0] prev_bwn = '1;
  bit            prev_oe_n = 1'b1;
  logic [DW-1:0] prev_data = '0;
  string         prev_tag = "R1";

  localparam logic [2:0] SEL = 3'b010; // {sel_a_n, sel_b, sel_c_n}

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [31:0] h;
    h = 32'(a) * 32'h0100_0193 ^ 32'(salt) * 32'h9E37_79B9;
    return {4'(salt + a), h};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got valid/data=%h expected %h", tag, act, exp);
    end
  endtask

  // outputs now reflect the command taken at the last edge
  task automatic check_out();
    logic          ev;
    logic [DW-1:0] ed;
    if (prev_kind == K_RD && !prev_oe_n) begin
      ev = 1'b1;
      ed = ref_mem[prev_addr];
    end else begin
      ev = 1'b0;
      ed = '0;
    end
    check((rvalid === ev) && (rdata === ed), prev_tag, {rvalid, rdata}, {ev, ed});
  endtask

  task automatic step(input bit sus, input bit ld_n, input bit wrn, input logic [2:0] ce,
                      input int a, input logic [NL-1:0] bwn, input bit oen,
                      input logic [DW-1:0] d, input string tag);
    int op;
    check_out();
    if (!sus && prev_kind == K_WR) begin
      wdata = prev_data;
      for (int i = 0; i < NL; i++)
        if (!prev_bwn[i]) ref_mem[prev_addr][i*LW +: LW] = prev_data[i*LW +: LW];
    end else begin
      wdata = pat(a + 3, 99);
    end
    suspend   = sus;
    load_n    = ld_n;
    wr_n      = wrn;
    {sel_a_n, sel_b, sel_c_n} = ce;
    addr      = AW'(a);
    byte_wr_n = bwn;
    oe_n      = oen;
    if (!sus) begin
      if (!ld_n) op = (ce == SEL) ? (wrn ? K_RD : K_WR) : K_IDLE;
      else       op = last_op;
      last_op   = op;
      prev_kind = op;
      prev_addr = a;
      prev_bwn  = bwn;
      prev_oe_n = oen;
      prev_data = d;
      prev_tag  = tag;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [NL-1:0] bwn, input logic [DW-1:0] d,
                    input string tag);
    step(1'b0, 1'b0, 1'b0, SEL, a, bwn, 1'b0, d, tag);
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 1'b0, 1'b1, SEL, a, '1, 1'b0, '0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    check((rvalid === 1'b0) && (rdata === '0), "R1", {rvalid, rdata}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, 3'b111, 0, '1, 1'b1, '0, "R1");

    // R4: fill every word with full masks, R3: read all back
    for (int a = 0; a < NW; a++) wr(a, 4'b0000, pat(a, 1), "R4");
    for (int a = 0; a < NW; a++) rd(a, "R3");

    // R4/R9: every mask value on one address, each read back
    for (int m = 0; m < 16; m++) begin
      wr(3, 4'(m), pat(m, 2), (m == 15) ? "R9" : "R4");
      rd(0, "R4");
      rd(3, (m == 15) ? "R9" : "R4");
    end

    // R5/R6: write then read same address on next cycle, partial masks
    for (int a = 0; a < NW; a++) begin
      wr(a, 4'(a), pat(a, 3), "R6");
      rd(a, "R5");
    end
    for (int a = 0; a < NW; a++) begin
      wr(a, 4'b0000, pat(a, 4), "R6");
      rd((a + 5) % NW, "R6");
      wr((a + 1) % NW, 4'b1010, pat(a, 5), "R6");
      rd((a + 1) % NW, "R5");
    end

    // R3: output enable off
    step(1'b0, 1'b0, 1'b1, SEL, 1, '1, 1'b1, '0, "R3");
    rd(1, "R3");

    // R2: every select combination as a write to address 5
    for (int c = 0; c < 8; c++) begin
      wr(7, 4'b0000, pat(c, 6), "R2");
      step(1'b0, 1'b0, 1'b0, 3'(c), 5, 4'b0000, 1'b0, pat(c, 7), "R2");
      step(1'b0, 1'b0, 1'b1, 3'(c), 5, '1, 1'b0, '0, "R2");
      rd(5, "R2");
    end

    // R7: suspended edges ignore commands and write data
    wr(7, 4'b0000, pat(7, 8), "R7");
    step(1'b1, 1'b0, 1'b0, SEL, 8, 4'b0000, 1'b0, pat(8, 9), "R7");
    rd(7, "R7");
    step(1'b1, 1'b0, 1'b0, SEL, 9, 4'b0000, 1'b0, pat(9, 9), "R7");
    step(1'b1, 1'b0, 1'b1, SEL, 9, '1, 1'b1, '0, "R7");
    rd(8, "R7");
    rd(9, "R7");
    rd(7, "R7");

    // R8: continuation ignores wr_n and selects
    wr(2, 4'b0000, pat(2, 10), "R8");
    step(1'b0, 1'b1, 1'b1, 3'b111, 4, 4'b0011, 1'b0, pat(4, 10), "R8");
    rd(2, "R8");
    step(1'b0, 1'b1, 1'b0, 3'b000, 4, 4'b0000, 1'b0, '0, "R8");
    step(1'b0, 1'b0, 1'b0, 3'b000, 6, 4'b0000, 1'b0, '0, "R8");
    step(1'b0, 1'b1, 1'b0, SEL, 6, 4'b0000, 1'b0, pat(6, 11), "R8");
    rd(6, "R8");
    rd(4, "R8");

    // R6: random mix with stalls, continuations and deselects
    for (int n = 0; n < 3000; n++) begin
      bit            s, l, w, o;
      logic [2:0]    ce;
      s  = ($urandom % 8) == 0;
      l  = ($urandom % 4) == 0;
      w  = $urandom % 2;
      o  = ($urandom % 8) == 0;
      ce = (($urandom % 8) == 0) ? 3'($urandom) : SEL;
      step(s, l, w, ce, int'($urandom % NW), 4'($urandom), o,
           pat(n, 12 + ($urandom % 4)), "R6");
    end
    rd(0, "R6");
    step(1'b0, 1'b0, 1'b1, 3'b111, 0, '1, 1'b1, '0, "R6");
    step(1'b0, 1'b0, 1'b1, 3'b111, 0, '1, 1'b1, '0, "R6");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule